// File: doc/BRIEF.md
# SPI Command Engine Register and Interrupt Front-End

This block is the software-facing side of a command-driven SPI sequencer. A host reaches it through a simple 32-bit register port with separate read and write strobes. Through that port the host queues 16-bit sequencer commands and outgoing data bytes, and drains incoming bytes. It also checks how much space or data each queue holds, and controls a soft reset that keeps the sequencer and every queue idle.

The sequencer sits outside the block. It pulls commands and outgoing bytes through two valid/ready output streams and pushes received bytes through one valid/ready input stream. When it finishes a synchronisation command, it reports the command's 8-bit tag on a one-cycle strobe. The block builds four interrupt causes from these queues and from the sync strobe, and drives a single level interrupt line.

Back-pressure rules:
- An output stream transfers a word on a clock edge where valid and ready are both high.
- While ready stays low, valid stays high and the data does not change.
- The input stream is accepted only while `sdi_ready` is high. `sdi_ready` drops when the receive queue is full or the block is in soft reset.

Top module: `spie_regfront`

## Requirements
- R1: A read of offset 0x00 returns 0x0001_0000 with the minor version in bits [15:8] and the patch level in bits [7:0] (defaults 0x00 and 0x61).
- R2: The soft-reset bit (offset 0x40, bit 0) is 1 after `rst_n`. While it is 1, `engine_rst` is high, `cmd_valid`, `sdo_valid` and `sdi_ready` are low, all queues are emptied and writes to the queues are dropped. Writing 0 to it releases the block.
- R3: A write to 0xE0 queues bits [15:0] as a command. Commands leave on the command stream in write order. Offset 0xD0 reads the free command slots (depth minus fill).
- R4: A write to 0xE4 queues bits [7:0] as an outgoing byte. Bytes leave on the output data stream in order. Offset 0xD4 reads the free slots.
- R5: Bytes accepted on the input stream are stored in order. Offset 0xD8 reads the number stored. A read of 0xE8 returns the oldest byte and removes it. A read of 0xEC returns the oldest byte and leaves the queue unchanged.
- R6: A read of 0xE8 or 0xEC with the receive queue empty returns 0, and the fill count stays 0.
- R7: A write to a full queue is dropped. Its free-slot count stays 0 and its stored words are unchanged.
- R8: Offset 0x84 reads the pending causes. These are: bit 0, command fill at or below CMD_AE_LVL; bit 1, output-byte fill at or below SDO_AE_LVL; bit 2, receive fill at or above SDI_AF_LVL. Bits 0 to 2 follow the fill levels and are not held. Bit 3 is the held sync event.
- R9: A `sync_valid` strobe outside soft reset stores `sync_id` (read at 0xC0) and sets pending bit 3. Writing 1 to bit 3 of 0x84 clears it, and writing 0 leaves it set. A strobe in the same cycle as the clear leaves it set.
- R10: Offset 0x80 bits [3:0] hold the interrupt enables. Offset 0x88 reads pending AND enable, and `irq` is high exactly when that value is nonzero.
- R11: Read data appears on `bus_rdata` from the clock edge that samples `bus_rd`. Offsets outside the map read 0.
- R12: Each output stream holds `valid` and its data stable while `ready` is low, and a word leaves only on a valid-and-ready edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| cmd_valid | output | 1 | Command stream valid |
| cmd_ready | input | 1 | Command stream ready |
| cmd_data | output | 16 | Command word |
| sdo_valid | output | 1 | Outgoing byte stream valid |
| sdo_ready | input | 1 | Outgoing byte stream ready |
| sdo_data | output | 8 | Outgoing byte |
| sdi_valid | input | 1 | Received byte stream valid |
| sdi_ready | output | 1 | Received byte stream ready |
| sdi_data | input | 8 | Received byte |
| sync_valid | input | 1 | Sync command completed strobe |
| sync_id | input | 8 | Tag of the completed sync command |
| engine_rst | output | 1 | Soft reset to the sequencer |
| irq | output | 1 | Level interrupt |

## Verification
The bench sweeps every fill count from zero through one past the depth on all three queues.
- A wrong full test would let the free count wrap or overwrite a stored word.
- A wrong watermark comparison would flip the almost-empty or almost-full bit one level early or late.
- Draining the receive queue past empty shows whether a pop on an empty queue corrupts the count or returns stale data, and whether a peek silently removes a byte.
- The sync event is hit with a write of 0, a write of 1, and a clear that lands in the same cycle as a new strobe. A design where the clear wins would lose a completion.

// File: rtl/spie_pkg.sv
`timescale 1ns/1ps
package spie_pkg;
  localparam logic [7:0] A_VERSION = 8'h00;
  localparam logic [7:0] A_SRST    = 8'h40;
  localparam logic [7:0] A_IRQ_EN  = 8'h80;
  localparam logic [7:0] A_IRQ_PND = 8'h84;
  localparam logic [7:0] A_IRQ_SRC = 8'h88;
  localparam logic [7:0] A_SYNC    = 8'hC0;
  localparam logic [7:0] A_CMD_RM  = 8'hD0;
  localparam logic [7:0] A_SDO_RM  = 8'hD4;
  localparam logic [7:0] A_SDI_LV  = 8'hD8;
  localparam logic [7:0] A_CMD_WR  = 8'hE0;
  localparam logic [7:0] A_SDO_WR  = 8'hE4;
  localparam logic [7:0] A_SDI_POP = 8'hE8;
  localparam logic [7:0] A_SDI_PK  = 8'hEC;

  localparam int NCAUSE = 4;
  typedef enum int {C_CMD_LOW = 0, C_SDO_LOW = 1, C_SDI_HIGH = 2, C_SYNC = 3} cause_e;
endpackage

// File: rtl/spie_fifo.sv
`timescale 1ns/1ps
module spie_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] cnt;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full  = (cnt == LW'(DEPTH));
  assign empty = (cnt == '0);
  assign do_wr = wr_en && !full && !flush;
  assign do_rd = rd_en && !empty && !flush;
  assign level = cnt;
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_wr) wptr <= step(wptr);
      if (do_rd) rptr <= step(rptr);
      cnt <= cnt + LW'(do_wr) - LW'(do_rd);
    end
  end
endmodule

// File: rtl/spie_irq.sv
`timescale 1ns/1ps
module spie_irq
  import spie_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-2:0] lvl_cause,
  input  logic              sync_set,
  input  logic              clr_we,
  input  logic [NCAUSE-1:0] clr_mask,
  input  logic              en_we,
  input  logic [NCAUSE-1:0] en_val,
  output logic [NCAUSE-1:0] pending,
  output logic [NCAUSE-1:0] enable,
  output logic [NCAUSE-1:0] source,
  output logic              irq
);
  logic sync_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_hold <= 1'b0;
      enable    <= '0;
    end else begin
      if (sync_set)                       sync_hold <= 1'b1;
      else if (clr_we && clr_mask[C_SYNC]) sync_hold <= 1'b0;
      if (en_we) enable <= en_val;
    end
  end

  assign pending = {sync_hold, lvl_cause};
  assign source  = pending & enable;
  assign irq     = |source;
endmodule

// File: rtl/spie_regfront.sv
`timescale 1ns/1ps
module spie_regfront
  import spie_pkg::*;
#(
  parameter int         CMD_W      = 16,
  parameter int         BYTE_W     = 8,
  parameter int         SYNC_W     = 8,
  parameter int         CMD_DEPTH  = 4,
  parameter int         SDO_DEPTH  = 4,
  parameter int         SDI_DEPTH  = 4,
  parameter int         CMD_AE_LVL = 1,
  parameter int         SDO_AE_LVL = 1,
  parameter int         SDI_AF_LVL = 3,
  parameter logic [7:0] VER_MINOR  = 8'h00,
  parameter logic [7:0] VER_PATCH  = 8'h61
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [CMD_W-1:0]  cmd_data,
  output logic              sdo_valid,
  input  logic              sdo_ready,
  output logic [BYTE_W-1:0] sdo_data,
  input  logic              sdi_valid,
  output logic              sdi_ready,
  input  logic [BYTE_W-1:0] sdi_data,
  input  logic              sync_valid,
  input  logic [SYNC_W-1:0] sync_id,
  output logic              engine_rst,
  output logic              irq
);
  localparam int CMD_LW = $clog2(CMD_DEPTH + 1);
  localparam int SDO_LW = $clog2(SDO_DEPTH + 1);
  localparam int SDI_LW = $clog2(SDI_DEPTH + 1);

  logic                srst;
  logic [SYNC_W-1:0]   last_sync;
  logic                cmd_empty, cmd_full, sdo_empty, sdo_full, sdi_empty, sdi_full;
  logic [CMD_LW-1:0]   cmd_lvl, cmd_room;
  logic [SDO_LW-1:0]   sdo_lvl, sdo_room;
  logic [SDI_LW-1:0]   sdi_lvl;
  logic [BYTE_W-1:0]   sdi_head;
  logic [NCAUSE-1:0]   pend, en, src;
  logic [NCAUSE-2:0]   lvl_cause;
  logic [31:0]         rd_mux;
  logic                wr_hit_cmd, wr_hit_sdo, rd_hit_pop;
  logic                unused_wdata;

  assign unused_wdata = ^bus_wdata[31:CMD_W];

  // soft reset holds the sequencer and queues idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             srst <= 1'b1;
    else if (bus_wr && bus_addr == A_SRST)  srst <= bus_wdata[0];
  end
  assign engine_rst = srst;

  assign wr_hit_cmd = bus_wr && (bus_addr == A_CMD_WR) && !srst;
  assign wr_hit_sdo = bus_wr && (bus_addr == A_SDO_WR) && !srst;
  assign rd_hit_pop = bus_rd && (bus_addr == A_SDI_POP);

  spie_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_n), .flush(srst),
    .wr_en(wr_hit_cmd), .wr_data(bus_wdata[CMD_W-1:0]),
    .rd_en(cmd_valid && cmd_ready), .rd_data(cmd_data),
    .empty(cmd_empty), .full(cmd_full), .level(cmd_lvl));

  spie_fifo #(.W(BYTE_W), .DEPTH(SDO_DEPTH)) u_sdoq (
    .clk(clk), .rst_n(rst_n), .flush(srst),
    .wr_en(wr_hit_sdo), .wr_data(bus_wdata[BYTE_W-1:0]),
    .rd_en(sdo_valid && sdo_ready), .rd_data(sdo_data),
    .empty(sdo_empty), .full(sdo_full), .level(sdo_lvl));

  spie_fifo #(.W(BYTE_W), .DEPTH(SDI_DEPTH)) u_sdiq (
    .clk(clk), .rst_n(rst_n), .flush(srst),
    .wr_en(sdi_valid && sdi_ready), .wr_data(sdi_data),
    .rd_en(rd_hit_pop), .rd_data(sdi_head),
    .empty(sdi_empty), .full(sdi_full), .level(sdi_lvl));

  // streams are gated during the cycle between reset request and flush
  assign cmd_valid = !cmd_empty && !srst;
  assign sdo_valid = !sdo_empty && !srst;
  assign sdi_ready = !sdi_full && !srst;

  assign cmd_room = CMD_LW'(CMD_DEPTH) - cmd_lvl;
  assign sdo_room = SDO_LW'(SDO_DEPTH) - sdo_lvl;

  // watermark causes follow the fill level directly
  assign lvl_cause[C_CMD_LOW]  = (cmd_lvl <= CMD_LW'(CMD_AE_LVL));
  assign lvl_cause[C_SDO_LOW]  = (sdo_lvl <= SDO_LW'(SDO_AE_LVL));
  assign lvl_cause[C_SDI_HIGH] = (sdi_lvl >= SDI_LW'(SDI_AF_LVL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   last_sync <= '0;
    else if (sync_valid && !srst) last_sync <= sync_id;
  end

  spie_irq u_irq (
    .clk(clk), .rst_n(rst_n), .lvl_cause(lvl_cause),
    .sync_set(sync_valid && !srst),
    .clr_we(bus_wr && bus_addr == A_IRQ_PND), .clr_mask(bus_wdata[NCAUSE-1:0]),
    .en_we(bus_wr && bus_addr == A_IRQ_EN), .en_val(bus_wdata[NCAUSE-1:0]),
    .pending(pend), .enable(en), .source(src), .irq(irq));

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_VERSION: rd_mux = {8'h00, 8'h01, VER_MINOR, VER_PATCH};
      A_SRST:    rd_mux = 32'(srst);
      A_IRQ_EN:  rd_mux = 32'(en);
      A_IRQ_PND: rd_mux = 32'(pend);
      A_IRQ_SRC: rd_mux = 32'(src);
      A_SYNC:    rd_mux = 32'(last_sync);
      A_CMD_RM:  rd_mux = 32'(cmd_room);
      A_SDO_RM:  rd_mux = 32'(sdo_room);
      A_SDI_LV:  rd_mux = 32'(sdi_lvl);
      A_SDI_POP,
      A_SDI_PK:  rd_mux = sdi_empty ? 32'h0 : 32'(sdi_head);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/spie_regfront_chk.sv
`timescale 1ns/1ps
module spie_regfront_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [15:0] cmd_data,
  input logic        sdo_valid,
  input logic        sdo_ready,
  input logic [7:0]  sdo_data,
  input logic        sdi_ready,
  input logic        sync_valid,
  input logic        engine_rst,
  input logic        irq
);
  logic mapped;
  logic srst_req;
  assign mapped = bus_addr inside {8'h00, 8'h40, 8'h80, 8'h84, 8'h88, 8'hC0,
                                   8'hD0, 8'hD4, 8'hD8, 8'hE0, 8'hE4, 8'hE8, 8'hEC};
  assign srst_req = bus_wr && bus_addr == 8'h40 && bus_wdata[0];

  // R1
  version_major_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 8'h00 |=> bus_rdata[23:16] == 8'h01);
  // R2
  idle_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    engine_rst |-> !cmd_valid && !sdo_valid && !sdi_ready);
  // R9
  sync_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_valid && !engine_rst) ##1 (bus_rd && bus_addr == 8'h84) |=> bus_rdata[3]);
  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 8'h80 && bus_wdata[3:0] == 4'h0 |=> !irq);
  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !mapped |=> bus_rdata == 32'h0);
  // R12
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready && !srst_req |=> cmd_valid && $stable(cmd_data));
  // R12
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_valid && !sdo_ready && !srst_req |=> sdo_valid && $stable(sdo_data));
endmodule

bind spie_regfront spie_regfront_chk u_chk (.*);

// File: tb/spie_regfront_test.sv
`timescale 1ns/1ps
module spie_regfront_test;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cmd_valid, cmd_ready = 1'b0;
  logic [15:0] cmd_data;
  logic        sdo_valid, sdo_ready = 1'b0;
  logic [7:0]  sdo_data;
  logic        sdi_valid = 1'b0, sdi_ready;
  logic [7:0]  sdi_data = '0;
  logic        sync_valid = 1'b0;
  logic [7:0]  sync_id = '0;
  logic        engine_rst, irq;

  int nvec = 0;
  int nbad = 0;

  always #2.5 clk = ~clk;

  spie_regfront uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic flush_all();
    wr(8'h40, 32'h1);
    wr(8'h40, 32'h0);
  endtask

  function automatic logic [15:0] cmd_pat(input int i);
    return 16'hC100 + 16'(i) * 16'h0101;
  endfunction

  initial begin
    #500000;
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    rd(8'h40, v); chk("R2 srst after reset", v, 32'h1);
    chk("R2 engine_rst", 32'(engine_rst), 32'h1);
    chk("R2 outputs idle", {29'h0, cmd_valid, sdo_valid, sdi_ready}, 32'h0);
    chk("R10 irq at reset", 32'(irq), 32'h0);
    wr(8'hE0, 32'h1234);
    wr(8'hE4, 32'h55);
    wr(8'h40, 32'h0);
    rd(8'hD0, v); chk("R2 cmd write dropped in reset", v, DEPTH);
    rd(8'hD4, v); chk("R2 sdo write dropped in reset", v, DEPTH);
    chk("R2 engine_rst released", 32'(engine_rst), 32'h0);
    // R1, R11
    rd(8'h00, v); chk("R1 version", v, 32'h0001_0061);
    rd(8'h44, v); chk("R11 unmapped", v, 32'h0);
    rd(8'hE0, v); chk("R11 write-only port reads 0", v, 32'h0);

    // R3 R7 R8 command sweep
    for (int n = 0; n <= DEPTH + 1; n++) begin
      int kept, got;
      flush_all();
      for (int i = 0; i < n; i++) wr(8'hE0, 32'(cmd_pat(i)) | 32'hABCD_0000);
      kept = (n > DEPTH) ? DEPTH : n;
      rd(8'hD0, v); chk("R3 R7 cmd room", v, 32'(DEPTH - kept));
      rd(8'h84, v); chk("R8 cmd almost empty", 32'(v[0]), 32'(kept <= 1));
      got = 0;
      @(negedge clk); cmd_ready = 1'b0;
      chk("R12 cmd held without ready", 32'(cmd_valid), 32'(kept > 0));
      cmd_ready = 1'b1;
      for (int c = 0; c < DEPTH + 2; c++) begin
        if (cmd_valid) begin
          chk("R3 R7 cmd order", 32'(cmd_data), 32'(cmd_pat(got)));
          got++;
        end
        @(negedge clk);
      end
      cmd_ready = 1'b0;
      chk("R3 cmd count delivered", got, kept);
    end

    // R4 R7 R8 output byte sweep
    for (int n = 0; n <= DEPTH + 1; n++) begin
      int kept, got;
      flush_all();
      for (int i = 0; i < n; i++) wr(8'hE4, 32'h0000_5A00 | 32'(8'h10 + 8'(i) * 8'h11));
      kept = (n > DEPTH) ? DEPTH : n;
      rd(8'hD4, v); chk("R4 R7 sdo room", v, 32'(DEPTH - kept));
      rd(8'h84, v); chk("R8 sdo almost empty", 32'(v[1]), 32'(kept <= 1));
      got = 0;
      @(negedge clk); sdo_ready = 1'b1;
      for (int c = 0; c < DEPTH + 2; c++) begin
        if (sdo_valid) begin
          chk("R4 R7 sdo order", 32'(sdo_data), 32'(8'h10 + 8'(got) * 8'h11));
          got++;
        end
        @(negedge clk);
      end
      sdo_ready = 1'b0;
      chk("R4 sdo count delivered", got, kept);
    end

    // R5 R6 R7 R8 receive sweep
    for (int k = 0; k <= DEPTH + 1; k++) begin
      int kept;
      flush_all();
      for (int j = 0; j < k; j++) begin
        @(negedge clk); sdi_valid = 1'b1; sdi_data = 8'h30 + 8'(j);
      end
      @(negedge clk); sdi_valid = 1'b0;
      kept = (k > DEPTH) ? DEPTH : k;
      chk("R7 sdi_ready when full", 32'(sdi_ready), 32'(kept < DEPTH));
      rd(8'hD8, v); chk("R5 sdi level", v, kept);
      rd(8'h84, v); chk("R8 sdi almost full", 32'(v[2]), 32'(kept >= 3));
      rd(8'hEC, v); chk("R5 R6 peek head", v, (kept > 0) ? 32'h30 : 32'h0);
      rd(8'hD8, v); chk("R5 peek keeps level", v, kept);
      for (int p = 0; p <= kept; p++) begin
        rd(8'hE8, v); chk("R5 R6 pop data", v, (p < kept) ? 32'(8'h30 + 8'(p)) : 32'h0);
      end
      rd(8'hD8, v); chk("R6 level after empty pop", v, 32'h0);
    end

    // R9 R10 sync and interrupts
    flush_all();
    wr(8'h80, 32'h8);
    @(negedge clk); sync_valid = 1'b1; sync_id = 8'h5A;
    @(negedge clk); sync_valid = 1'b0;
    chk("R9 R10 irq on sync", 32'(irq), 32'h1);
    rd(8'hC0, v); chk("R9 sync id", v, 32'h5A);
    rd(8'h84, v); chk("R8 R9 pending", v, 32'hB);
    rd(8'h88, v); chk("R10 source", v, 32'h8);
    wr(8'h84, 32'h7);
    rd(8'h84, v); chk("R9 write 0 keeps sync", 32'(v[3]), 32'h1);
    wr(8'h84, 32'h8);
    rd(8'h84, v); chk("R9 clear sync", 32'(v[3]), 32'h0);
    chk("R10 irq after clear", 32'(irq), 32'h0);
    @(negedge clk); sync_valid = 1'b1; sync_id = 8'h77;
    bus_wr = 1'b1; bus_addr = 8'h84; bus_wdata = 32'h8;
    @(negedge clk); sync_valid = 1'b0; bus_wr = 1'b0;
    rd(8'h84, v); chk("R9 set wins over clear", 32'(v[3]), 32'h1);
    rd(8'hC0, v); chk("R9 sync id update", v, 32'h77);
    wr(8'h84, 32'hF);
    wr(8'h40, 32'h1);
    @(negedge clk); sync_valid = 1'b1; sync_id = 8'h99;
    @(negedge clk); sync_valid = 1'b0;
    wr(8'h40, 32'h0);
    rd(8'h84, v); chk("R2 R9 sync ignored in reset", 32'(v[3]), 32'h0);
    rd(8'hC0, v); chk("R2 R9 id kept in reset", v, 32'h77);
    wr(8'h80, 32'h1);
    chk("R10 irq from cmd low level", 32'(irq), 32'h1);
    rd(8'h80, v); chk("R10 enable readback", v, 32'h1);
    for (int i = 0; i < 3; i++) wr(8'hE0, 32'(i));
    chk("R8 R10 irq drops above watermark", 32'(irq), 32'h0);
    rd(8'h88, v); chk("R10 source empty", v, 32'h0);
    wr(8'h40, 32'h1);
    chk("R2 cmd_valid gated", 32'(cmd_valid), 32'h0);
    wr(8'h40, 32'h0);
    rd(8'hD0, v); chk("R2 flush empties cmd", v, DEPTH);
    wr(8'h80, 32'h0);
    chk("R10 irq masked", 32'(irq), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule